// File: doc/BRIEF.md
# Slotted Ethernet Receive Buffer

This block accepts received Ethernet frames as a byte stream and writes each one into a fixed-size slot of an on-chip buffer. There are two slots of 2048 bytes each, and the slot base is the slot index shifted left by 11. Slots are filled in turn. Once a frame is complete, the block records its byte count and posts an event. From that point the slot belongs to software until the event is acknowledged.

Software polls a status register or waits for the interrupt. It then reads the oldest waiting slot index and its frame length from the register file, and fetches the payload through a 32-bit read window into the buffer. Writing 1 to the pending register acknowledges the frame and is the only way a slot returns to the free pool.

Two kinds of frame are discarded, and neither uses up a slot. A frame that begins while every slot is held is dropped whole and counted in a saturating counter. A frame longer than 1530 bytes is discarded without being posted.

Top module: `rxslot_buf`

## Requirements
- R1: After reset, every register reads 0: slot (address 0), length (1), status (2), pending (3), enable (4) and drop count (5). irq is low.
- R2: Byte k of a stored frame is at byte address (slot<<11)+k. The window reads 32-bit words at word address byte_address>>2, with byte k in bits 8*(k%4)+7 down to 8*(k%4). win_rdata is valid one clock after win_addr.
- R3: The length register (address 1) shows the byte count of the oldest waiting frame, or 0 when no frame is waiting. It updates only when a frame's last byte (in_last) is taken, never part-way through a frame.
- R4: Status (address 2) and pending (address 3) read 1 in bit 0 from the clock edge that takes the last byte of an accepted frame until every waiting frame has been acknowledged.
- R5: A register write to address 3 with reg_wbit=1 frees the oldest waiting slot. The same write with reg_wbit=0 changes nothing.
- R6: Accepted frames go to slots 0, 1, 0, 1 in turn. The slot register (address 0) reports the index of the oldest waiting frame.
- R7: irq is high exactly when a frame is waiting and the enable bit (address 4, bit 0, read/write) is 1. Status still reports a waiting frame while enable is 0.
- R8: A frame whose first byte arrives while both slots are held is dropped whole and leaves the stored slots unchanged. It increments the drop count (address 5), which saturates at 255.
- R9: A frame of exactly 1530 bytes is posted. A longer frame is not posted, and it does not use up its slot: the next frame is stored in that same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wbit | input | 1 | Write data (all writable fields are one bit) |
| reg_rdata | output | 32 | Register read data, combinational |
| win_addr | input | 10 | Buffer window word address |
| win_rdata | output | 32 | Buffer window read data, one cycle latency |
| irq | output | 1 | Frame-waiting interrupt |

## Verification
The bench sweeps frame lengths from 1 to 8 bytes so that every tail alignment within a 32-bit word is read back. It also sends 13, 64, 1529 and 1530 bytes, to cover multi-word payloads and the largest accepted frame. A frame sent in two bursts with a gap between them shows whether the length leaks out before the last byte. Back-to-back traffic with both slots held separates a whole-frame drop from corruption of the stored slots, and a long run of such frames separates a saturating counter from one that wraps. A 1531-byte frame followed by a short one shows whether an oversize frame is rejected and whether it wrongly advances the slot rotation.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;
   typedef enum logic [2:0] {
      RSEL_SLOT    = 3'd0,
      RSEL_LEN     = 3'd1,
      RSEL_STATUS  = 3'd2,
      RSEL_PENDING = 3'd3,
      RSEL_ENABLE  = 3'd4,
      RSEL_DROPS   = 3'd5
   } rsel_e;
endpackage

// File: rtl/rxslot_sram.sv
module rxslot_sram #(
   parameter int WORDS   = 1024,
   parameter int WORD_W  = 32,
   parameter int ADDR_W  = 10,
   parameter int LANE_W  = 2
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [7:0]        wr_byte,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr][wr_lane*8 +: 8] <= wr_byte;
      rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/rxslot_fill.sv
module rxslot_fill #(
   parameter int SLOT_W    = 1,
   parameter int SLOT_LOG2 = 11,
   parameter int MAX_FRAME = 1530,
   parameter int DROP_W    = 8,
   localparam int POS_W    = $clog2(MAX_FRAME + 1),
   localparam int BYTE_AW  = SLOT_W + SLOT_LOG2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   input  logic               has_free,
   input  logic [SLOT_W-1:0]  alloc_slot,
   output logic               mem_we,
   output logic [BYTE_AW-1:0] mem_byte_addr,
   output logic [7:0]         mem_byte,
   output logic               post,
   output logic [POS_W-1:0]   post_len,
   output logic [DROP_W-1:0]  drops
);
   logic             in_frame_q, keep_q, keep, fits, start;
   logic [POS_W-1:0] pos_q, cur_pos;

   assign start    = in_valid && !in_frame_q;
   assign keep     = in_frame_q ? keep_q : has_free;
   assign cur_pos  = in_frame_q ? pos_q : '0;
   assign fits     = cur_pos < POS_W'(MAX_FRAME);

   assign mem_we        = in_valid && keep && fits;
   assign mem_byte_addr = {alloc_slot, SLOT_LOG2'(cur_pos)};
   assign mem_byte      = in_data;
   assign post          = in_valid && in_last && keep && fits;
   assign post_len      = cur_pos + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         keep_q     <= 1'b0;
         pos_q      <= '0;
         drops      <= '0;
      end else if (in_valid) begin
         in_frame_q <= !in_last;
         keep_q     <= keep;
         pos_q      <= fits ? cur_pos + 1'b1 : cur_pos;
         if (start && !has_free && drops != '1) drops <= drops + 1'b1;
      end
   end

   AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (drops == '1) |=> (drops == '1)); // R8
   AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (drops != $past(drops)) |-> (drops == $past(drops) + 1'b1)); // R8
endmodule

// File: rtl/rxslot_queue.sv
module rxslot_queue #(
   parameter int NUM_SLOTS = 2,
   parameter int LEN_W     = 11,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
   localparam bit POW2     = (NUM_SLOTS & (NUM_SLOTS - 1)) == 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [LEN_W-1:0]  push_len,
   input  logic              pop_req,
   output logic              has_free,
   output logic [SLOT_W-1:0] alloc_slot,
   output logic [SLOT_W-1:0] head_slot,
   output logic [LEN_W-1:0]  head_len,
   output logic              any_pending
);
   logic [SLOT_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  count;
   logic [LEN_W-1:0]  len_q [NUM_SLOTS];
   logic              pop;

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == SLOT_W'(NUM_SLOTS - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == SLOT_W'(NUM_SLOTS - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign any_pending = count != '0;
   assign has_free    = count < CNT_W'(NUM_SLOTS);
   assign pop         = pop_req && any_pending;
   assign alloc_slot  = wr_ptr;
   assign head_slot   = rd_ptr;
   assign head_len    = any_pending ? len_q[rd_ptr] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < NUM_SLOTS; i++) len_q[i] <= '0;
      end else begin
         if (push) begin
            len_q[wr_ptr] <= push_len;
            wr_ptr        <= wr_nxt;
         end
         if (pop) rd_ptr <= rd_nxt;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(NUM_SLOTS))); // R8
   AST_FREE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (count < $past(count)) |-> $past(pop_req)); // R5
   AST_LEN_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(head_len) |-> $past(push || pop_req)); // R3
endmodule

// File: rtl/rxslot_buf.sv
module rxslot_buf
   import rxslot_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int SLOT_LOG2 = 11,
   parameter int MAX_FRAME = 1530,
   parameter int WORD_W    = 32,
   parameter int DROP_W    = 8,
   parameter int REG_DW    = 32,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int LEN_W    = $clog2(MAX_FRAME + 1),
   localparam int BYTE_AW  = SLOT_W + SLOT_LOG2,
   localparam int LANES    = WORD_W / 8,
   localparam int LANE_W   = $clog2(LANES),
   localparam int WORD_AW  = BYTE_AW - LANE_W,
   localparam int WORDS    = NUM_SLOTS << (SLOT_LOG2 - LANE_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic               reg_wbit,
   output logic [REG_DW-1:0]  reg_rdata,
   input  logic [WORD_AW-1:0] win_addr,
   output logic [WORD_W-1:0]  win_rdata,
   output logic               irq
);
   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("rxslot_buf: NUM_SLOTS must be at least 2");
      end
      if (MAX_FRAME > (1 << SLOT_LOG2)) begin : g_bad_frame
         $error("rxslot_buf: MAX_FRAME exceeds the slot size");
      end
      if ((WORD_W % 8) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_word
         $error("rxslot_buf: WORD_W must be a power-of-two number of bytes, at least 2");
      end
      if (REG_DW < LEN_W || REG_DW < DROP_W) begin : g_bad_reg
         $error("rxslot_buf: REG_DW too narrow for length or drop count");
      end
   endgenerate

   logic               has_free, any_pending, post, mem_we, en_q, pop_req;
   logic [SLOT_W-1:0]  alloc_slot, head_slot;
   logic [LEN_W-1:0]   post_len, head_len;
   logic [BYTE_AW-1:0] mem_byte_addr;
   logic [7:0]         mem_byte;
   logic [DROP_W-1:0]  drops;

   rxslot_fill #(
      .SLOT_W(SLOT_W), .SLOT_LOG2(SLOT_LOG2), .MAX_FRAME(MAX_FRAME), .DROP_W(DROP_W)
   ) u_fill (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .has_free(has_free), .alloc_slot(alloc_slot), .mem_we(mem_we),
      .mem_byte_addr(mem_byte_addr), .mem_byte(mem_byte), .post(post),
      .post_len(post_len), .drops(drops)
   );

   rxslot_queue #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(post), .push_len(post_len), .pop_req(pop_req),
      .has_free(has_free), .alloc_slot(alloc_slot), .head_slot(head_slot),
      .head_len(head_len), .any_pending(any_pending)
   );

   rxslot_sram #(.WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(WORD_AW), .LANE_W(LANE_W)) u_sram (
      .clk(clk), .wr_en(mem_we), .wr_addr(mem_byte_addr[BYTE_AW-1:LANE_W]),
      .wr_lane(mem_byte_addr[LANE_W-1:0]), .wr_byte(mem_byte),
      .rd_addr(win_addr), .rd_data(win_rdata)
   );

   assign pop_req = reg_wr && (reg_addr == RSEL_PENDING) && reg_wbit;
   assign irq     = any_pending && en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                                en_q <= 1'b0;
      else if (reg_wr && reg_addr == RSEL_ENABLE) en_q <= reg_wbit;
   end

   always_comb begin
      case (reg_addr)
         RSEL_SLOT:    reg_rdata = REG_DW'(head_slot);
         RSEL_LEN:     reg_rdata = REG_DW'(head_len);
         RSEL_STATUS,
         RSEL_PENDING: reg_rdata = REG_DW'(any_pending);
         RSEL_ENABLE:  reg_rdata = REG_DW'(en_q);
         RSEL_DROPS:   reg_rdata = REG_DW'(drops);
         default:      reg_rdata = '0;
      endcase
   end

   AST_IRQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && reg_addr == RSEL_ENABLE && !reg_wbit) |-> !irq); // R7
   AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      any_pending |-> (head_len != '0 && head_len <= LEN_W'(MAX_FRAME))); // R9
endmodule

// File: tb/sim_rxslot_buf.sv
module sim_rxslot_buf;
   localparam int SLOT_WORDS = 2048 / 4;
   localparam logic [2:0] A_SLOT = 3'd0, A_LEN = 3'd1, A_STAT = 3'd2,
                          A_PEND = 3'd3, A_EN = 3'd4, A_DROP = 3'd5;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0, reg_wr = 1'b0, reg_wbit = 1'b0;
   logic [7:0]  in_data = '0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_rdata, win_rdata;
   logic [9:0]  win_addr = '0;
   logic        irq;

   int checks = 0, errors = 0, alloc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rxslot_buf u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wbit(reg_wbit), .reg_rdata(reg_rdata),
      .win_addr(win_addr), .win_rdata(win_rdata), .irq(irq)
   );

   function automatic logic [7:0] pat(int seed, int i);
      return 8'(seed * 37 + i * 11 + (i >> 8));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_part(int seed, int from, int upto, bit with_last);
      for (int i = from; i < upto; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = pat(seed, i);
         in_last  = with_last && (i == upto - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic send(int seed, int len);
      send_part(seed, 0, len, 1'b1);
   endtask

   task automatic rd(logic [2:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   task automatic expect_reg(logic [2:0] a, int exp, string req);
      int v;
      rd(a, v);
      check(v == exp, req, v, exp);
   endtask

   task automatic wr(logic [2:0] a, bit b);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wbit = b;
      @(negedge clk);
      reg_wr = 1'b0; reg_wbit = 1'b0;
   endtask

   task automatic check_mem(int slot, int len, int seed, string req);
      int bad = 0, first_act = 0, first_exp = 0;
      for (int w = 0; w < (len + 3) / 4; w++) begin
         @(negedge clk);
         win_addr = 10'(slot * SLOT_WORDS + w);
         @(posedge clk);
         @(negedge clk);
         for (int k = 0; k < 4; k++) begin
            if (w * 4 + k < len && win_rdata[8*k +: 8] !== pat(seed, w * 4 + k)) begin
               if (bad == 0) begin
                  first_act = int'(win_rdata[8*k +: 8]);
                  first_exp = int'(pat(seed, w * 4 + k));
               end
               bad++;
            end
         end
      end
      check(bad == 0, req, first_act, first_exp);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      int lens [12] = '{1, 2, 3, 4, 5, 6, 7, 8, 13, 64, 1529, 1530};
      int a0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      expect_reg(A_SLOT, 0, "R1 slot");
      expect_reg(A_LEN, 0, "R1 length");
      expect_reg(A_STAT, 0, "R1 status");
      expect_reg(A_PEND, 0, "R1 pending");
      expect_reg(A_EN, 0, "R1 enable");
      expect_reg(A_DROP, 0, "R1 drops");
      check(irq == 1'b0, "R1 irq", int'(irq), 0);

      // R3 no partial length exposed mid-frame
      send_part(1, 0, 5, 1'b0);
      expect_reg(A_STAT, 0, "R3 status mid-frame");
      expect_reg(A_LEN, 0, "R3 length mid-frame");
      send_part(1, 5, 9, 1'b1);
      expect_reg(A_LEN, 9, "R3 length after last");
      check_mem(0, 9, 1, "R2 split frame data");
      wr(A_PEND, 1'b1);
      alloc = 1;

      // Length sweep: R2 R3 R4 R5 R6 R7 R9
      foreach (lens[j]) begin
         send(10 + j, lens[j]);
         expect_reg(A_STAT, 1, "R4 status");
         expect_reg(A_PEND, 1, "R4 pending");
         expect_reg(A_SLOT, alloc, "R6 slot rotation");
         expect_reg(A_LEN, lens[j], lens[j] == 1530 ? "R9 max length kept" : "R3 length");
         check(irq == 1'b0, "R7 irq masked", int'(irq), 0);
         check_mem(alloc, lens[j], 10 + j, "R2 payload");
         wr(A_PEND, 1'b1);
         expect_reg(A_STAT, 0, "R5 ack frees");
         alloc ^= 1;
      end

      // Both slots held, third frame dropped: R5 R6 R8
      a0 = alloc;
      send(40, 5);
      send(41, 7);
      send(42, 4);
      expect_reg(A_DROP, 1, "R8 drop count");
      expect_reg(A_SLOT, a0, "R6 oldest slot");
      expect_reg(A_LEN, 5, "R6 oldest length");
      wr(A_PEND, 1'b0);
      expect_reg(A_STAT, 1, "R5 zero write ignored");
      expect_reg(A_LEN, 5, "R5 zero write keeps length");
      check_mem(a0, 5, 40, "R8 first slot untouched");
      wr(A_PEND, 1'b1);
      expect_reg(A_SLOT, a0 ^ 1, "R6 next oldest");
      expect_reg(A_LEN, 7, "R6 next length");
      check_mem(a0 ^ 1, 7, 41, "R8 second slot untouched");
      wr(A_PEND, 1'b1);
      expect_reg(A_STAT, 0, "R5 all freed");

      // Oversize frame: R9
      send(50, 1531);
      expect_reg(A_STAT, 0, "R9 oversize not posted");
      send(51, 3);
      expect_reg(A_SLOT, alloc, "R9 slot not consumed");
      expect_reg(A_LEN, 3, "R9 following length");
      check_mem(alloc, 3, 51, "R9 following data");
      wr(A_PEND, 1'b1);
      alloc ^= 1;

      // Interrupt gating: R7
      wr(A_EN, 1'b1);
      expect_reg(A_EN, 1, "R7 enable readback");
      check(irq == 1'b0, "R7 irq idle", int'(irq), 0);
      send(60, 2);
      check(irq == 1'b1, "R7 irq raised", int'(irq), 1);
      wr(A_EN, 1'b0);
      check(irq == 1'b0, "R7 irq masked", int'(irq), 0);
      expect_reg(A_STAT, 1, "R7 poll while masked");
      wr(A_EN, 1'b1);
      check(irq == 1'b1, "R7 irq re-enabled", int'(irq), 1);
      wr(A_PEND, 1'b1);
      check(irq == 1'b0, "R7 irq after ack", int'(irq), 0);
      alloc ^= 1;

      // Drop counter saturation: R8
      send(70, 2);
      send(71, 2);
      for (int n = 0; n < 300; n++) send(72, 1);
      expect_reg(A_DROP, 255, "R8 drop saturates");
      expect_reg(A_LEN, 2, "R8 held frame intact");
      wr(A_PEND, 1'b1);
      wr(A_PEND, 1'b1);
      expect_reg(A_STAT, 0, "R5 cleared at end");

      done = 1'b1;
      finish_run();
   end
endmodule